// File: doc/BRIEF.md
# Four-Channel PCM Transmit Serializer

This block sends four 8-bit PCM samples, one for each channel, out on a bit clock. The samples leave in a frame that starts at the rising edge of a transmit frame sync. The bit clock reaches the block as a one-cycle strobe, `bitTick`, in the system clock domain, and every output update happens on a clock edge where that strobe is high. The sync is sampled only on those edges. A mode input chooses between two layouts. In parallel layout, each channel has its own lane and all four lanes share the same 8-bit slot. In serial layout, lane 0 carries the four channels one after the other as a 32-bit time-division frame.

Each lane models an open-drain pin as a data bit plus an output enable. A released lane reads as a pulled-up 1. An optional A-law mode inverts the alternate bits of every byte before it is sent. Two things are captured when a frame starts: the four sample words, and the choice of layout. A flag reports when serial layout is used with too few bit ticks in a frame to carry 32 bits.

Top module: `pcm_tx_serializer`

## Requirements
- R1: After reset, every lane enable is 0 and `cfgError` is 0.
- R2: A frame starts on a `bitTick` edge where `frameSync` is 1 and the sync sampled at the previous tick was 0. Right after that edge, lane 0 is enabled and shows the first bit, which is the most significant bit of channel 1.
- R3: Lane data and enables change only on edges where `bitTick` is 1.
- R4: In parallel layout (`modeParallel`=1), lane n carries channel n+1 (`chanData[8n+7:8n]`). The word goes MSB first during the first 8 ticks of the frame (the start tick plus 7 more), and all four lanes keep identical enable timing.
- R5: In serial layout (`modeParallel`=0), lane 0 sends 32 consecutive bits: channel 1, then 2, then 3, then 4, each MSB first. Lanes 1 to 3 stay released.
- R6: Outside its active slot a lane is released, with enable 0, and its data reads 1.
- R7: When `alawInvert` is 1 at frame start, each byte is XORed with 8'h55 before it is sent, so its 2nd, 4th, 6th and 8th bits from the MSB are inverted.
- R8: Sample words are captured at frame start. Changes to `chanData` during a frame do not affect the bits sent.
- R9: A new sync rise before the current frame has finished restarts transmission at the first bit of channel 1 with fresh samples.
- R10: At every frame start after the first, `cfgError` is set if serial layout is selected and the previous frame had fewer than 32 ticks. Otherwise it is cleared. It changes only at frame starts.
- R11: The layout and the A-law choice are sampled at frame start. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle strobe marking each rising bit-clock edge |
| frameSync | input | 1 | Transmit frame sync level, sampled on ticks |
| modeParallel | input | 1 | 1 selects four parallel lanes, 0 selects one TDM lane |
| alawInvert | input | 1 | 1 applies alternate-bit inversion |
| chanData | input | 32 | Channel words; channel n+1 at [8n+7:8n] |
| pcmData | output | 4 | Lane data bits (1 when released) |
| pcmOe | output | 4 | Lane drive enables |
| cfgError | output | 1 | Serial frame shorter than 32 ticks |

## Verification
The assertions assume that `bitTick` pulses are single cycles separated by idle cycles. They also assume that `frameSync` and the mode inputs are meaningful only at ticks, and that every frame contains at least one tick with the sync low, so that a later rise can be seen. The stimulus drives every input on the falling clock edge. It holds the sync high for one to three ticks at the start of each frame and makes frames at least four ticks long. It changes `chanData`, the layout and the A-law choice only in the idle cycles between ticks. This means R8 and R11 are exercised without breaking the sampling assumptions.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  typedef struct packed {
    logic load;      // frame start: capture words
    logic shift;     // advance one bit
    logic active;    // a slot is in progress
    logic parallel;  // layout captured at frame start
  } txStrobe_t;
endpackage

// File: rtl/pcm_tx_ctrl.sv
module pcm_tx_ctrl
  import pcm_tx_pkg::*;
#(
  parameter int WORD  = 8,
  parameter int LANES = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitTick,
  input  logic      frameSync,
  input  logic      modeParallel,
  output txStrobe_t strobe,
  output logic      cfgError
);
  localparam int FRAME_BITS = WORD * LANES;
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam int TS_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] LAST_PAR = CNT_W'(WORD - 1);
  localparam logic [CNT_W-1:0] LAST_SER = CNT_W'(FRAME_BITS - 1);
  localparam logic [TS_W-1:0] TS_LIMIT = TS_W'(FRAME_BITS - 1);

  logic syncPrev, active, parLatch, seenFrame;
  logic [CNT_W-1:0] bitCnt;
  logic [TS_W-1:0] ticksSince;
  logic syncRise, lastBit;

  assign syncRise = bitTick & frameSync & ~syncPrev;
  assign lastBit = (bitCnt == (parLatch ? LAST_PAR : LAST_SER));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncPrev   <= 1'b0;
      active     <= 1'b0;
      parLatch   <= 1'b0;
      seenFrame  <= 1'b0;
      bitCnt     <= '0;
      ticksSince <= '0;
      cfgError   <= 1'b0;
    end else if (bitTick) begin
      syncPrev <= frameSync;
      if (syncRise) begin
        active     <= 1'b1;
        bitCnt     <= '0;
        parLatch   <= modeParallel;
        seenFrame  <= 1'b1;
        ticksSince <= '0;
        cfgError   <= seenFrame && !modeParallel && (ticksSince < TS_LIMIT);
      end else begin
        if (ticksSince != '1) ticksSince <= ticksSince + 1'b1;
        if (active) begin
          if (lastBit) active <= 1'b0;
          else bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.load     = syncRise;
    strobe.shift    = bitTick & ~syncRise & active;
    strobe.active   = active;
    strobe.parallel = parLatch;
  end
endmodule

// File: rtl/pcm_tx_datapath.sv
module pcm_tx_datapath
  import pcm_tx_pkg::*;
#(
  parameter int WORD  = 8,
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  txStrobe_t             strobe,
  input  logic                  alawInvert,
  input  logic [WORD*LANES-1:0] chanData,
  output logic [LANES-1:0]      pcmData,
  output logic [LANES-1:0]      pcmOe
);
  localparam int FRAME_BITS = WORD * LANES;

  function automatic logic [WORD-1:0] altMask();
    logic [WORD-1:0] m;
    for (int b = 0; b < WORD; b++) m[b] = ~b[0];
    return m;
  endfunction

  logic [FRAME_BITS-1:0] shiftReg, loadWord;

  // channel 1 goes to the top so it leaves first
  always_comb begin
    for (int c = 0; c < LANES; c++)
      loadWord[FRAME_BITS-1-c*WORD -: WORD] =
        chanData[c*WORD +: WORD] ^ (alawInvert ? altMask() : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.load) shiftReg <= loadWord;
    else if (strobe.shift) shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b0};
  end

  for (genvar j = 0; j < LANES; j++) begin : gLane
    if (j == 0) begin : gHead
      assign pcmOe[j] = strobe.active;
    end else begin : gRest
      assign pcmOe[j] = strobe.active & strobe.parallel;
    end
    assign pcmData[j] = pcmOe[j] ? shiftReg[FRAME_BITS-1-j*WORD] : 1'b1;
  end
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer
  import pcm_tx_pkg::*;
#(
  parameter int WORD  = 8,
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  bitTick,
  input  logic                  frameSync,
  input  logic                  modeParallel,
  input  logic                  alawInvert,
  input  logic [WORD*LANES-1:0] chanData,
  output logic [LANES-1:0]      pcmData,
  output logic [LANES-1:0]      pcmOe,
  output logic                  cfgError
);
  txStrobe_t strobe;

  pcm_tx_ctrl #(.WORD(WORD), .LANES(LANES)) uCtrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .frameSync(frameSync),
    .modeParallel(modeParallel), .strobe(strobe), .cfgError(cfgError)
  );

  pcm_tx_datapath #(.WORD(WORD), .LANES(LANES)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .alawInvert(alawInvert),
    .chanData(chanData), .pcmData(pcmData), .pcmOe(pcmOe)
  );
endmodule

// File: rtl/pcm_tx_checker.sv
module pcm_tx_checker #(
  parameter int WORD  = 8,
  parameter int LANES = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  bitTick,
  input logic                  frameSync,
  input logic [WORD*LANES-1:0] chanData,
  input logic [LANES-1:0]      pcmData,
  input logic [LANES-1:0]      pcmOe,
  input logic                  cfgError
);
  logic chkSyncPrev;
  logic rise;
  always_ff @(posedge clk) begin
    if (!rstN) chkSyncPrev <= 1'b0;
    else if (bitTick) chkSyncPrev <= frameSync;
  end
  assign rise = bitTick & frameSync & ~chkSyncPrev;

  assert_first_bit_R2: assert property (@(posedge clk) disable iff (!rstN)
    rise |=> pcmOe[0] && (pcmData[0] == $past(chanData[WORD-1])));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> $stable(pcmOe) && $stable(pcmData));

  assert_lanes_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(pcmOe[LANES-1:1]) == 0) ||
    (pcmOe[0] && ($countones(pcmOe[LANES-1:1]) == LANES-1)));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    &(pcmData | pcmOe));

  assert_cfg_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rise |=> $stable(cfgError));
endmodule

bind pcm_tx_serializer pcm_tx_checker #(.WORD(WORD), .LANES(LANES)) uChk (
  .clk(clk), .rstN(rstN), .bitTick(bitTick), .frameSync(frameSync),
  .chanData(chanData), .pcmData(pcmData), .pcmOe(pcmOe), .cfgError(cfgError)
);

// File: tb/sim_pcm_tx_serializer.sv
module sim_pcm_tx_serializer;
  logic clk = 1'b0, rstN = 1'b0, bitTick = 1'b0, frameSync = 1'b0;
  logic modeParallel = 1'b0, alawInvert = 1'b0;
  logic [31:0] chanData = '0;
  logic [3:0] pcmData, pcmOe;
  logic cfgError;
  int checks = 0, fails = 0, cycles = 0;
  bit seen = 0;
  int prevLen = 0;

  always #5 clk = ~clk;

  pcm_tx_serializer u0 (.clk(clk), .rstN(rstN), .bitTick(bitTick),
    .frameSync(frameSync), .modeParallel(modeParallel), .alawInvert(alawInvert),
    .chanData(chanData), .pcmData(pcmData), .pcmOe(pcmOe), .cfgError(cfgError));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] coded(logic [31:0] d, int c, bit al);
    return d[c*8 +: 8] ^ (al ? 8'h55 : 8'h00);
  endfunction

  // expected lane outputs at tick k of a frame
  function automatic logic [7:0] expOe(bit par, int k);
    if (par) return (k < 8) ? 8'h0f : 8'h00;
    return (k < 32) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [7:0] expData(bit par, bit al, logic [31:0] d, int k);
    logic [7:0] r = 8'h0f;
    if (par) begin
      if (k < 8) for (int j = 0; j < 4; j++) r[j] = coded(d, j, al)[7-k];
    end else if (k < 32) begin
      r[0] = coded(d, k/8, al)[7-(k%8)];
    end
    return r;
  endfunction

  task automatic runFrame(int nTicks, bit par, bit al, int syncLen);
    logic [31:0] words;
    logic [7:0] eo, ed;
    modeParallel = par;
    alawInvert = al;
    chanData = $urandom;
    words = chanData;
    for (int k = 0; k < nTicks; k++) begin
      @(negedge clk);
      bitTick = 1'b1;
      frameSync = (k < syncLen);
      @(negedge clk);
      bitTick = 1'b0;
      eo = expOe(par, k);
      ed = expData(par, al, words, k);
      if (par) begin
        chk("R4 lane enables", {4'h0, pcmOe}, eo);
        chk("R4 lane data", {4'h0, pcmData}, ed);
      end else begin
        chk("R5 serial enables", {4'h0, pcmOe}, eo);
        chk("R5 serial data", {4'h0, pcmData}, ed);
      end
      if (k == 0) begin
        chk("R2 first bit", {6'h0, pcmOe[0], pcmData[0]}, {6'h0, 1'b1, words[7]});
        chk("R10 config flag", {7'h0, cfgError}, {7'h0, seen && !par && prevLen < 32});
      end
      if (eo == 8'h00) chk("R6 released data", {4'h0, pcmData}, 8'h0f);
      // R8 R11: disturb inputs between ticks
      chanData = $urandom;
      modeParallel = $urandom;
      alawInvert = $urandom;
      @(negedge clk);
      chk("R3 hold between ticks", {pcmOe, pcmData}, {eo[3:0], ed[3:0]});
    end
    seen = 1;
    prevLen = nTicks;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset enables", {4'h0, pcmOe}, 8'h00);
    chk("R1 reset flag", {7'h0, cfgError}, 8'h00);
    rstN = 1'b1;
    // directed
    runFrame(32, 1'b0, 1'b0, 1);   // R5 plain serial
    runFrame(34, 1'b0, 1'b1, 2);   // R7 serial with inversion
    runFrame(12, 1'b1, 1'b1, 3);   // R4 R7 parallel
    runFrame(8, 1'b0, 1'b0, 1);    // R10 prev 12 ticks -> flag; R9 cut short
    runFrame(20, 1'b0, 1'b0, 1);   // R10 prev 8 ticks -> flag; R9 cut
    runFrame(33, 1'b1, 1'b0, 1);   // R10 parallel clears
    runFrame(32, 1'b0, 1'b0, 1);   // R10 prev 33 -> clear
    runFrame(40, 1'b0, 1'b1, 2);   // R10 prev 32 -> clear
    runFrame(31, 1'b1, 1'b0, 1);
    runFrame(36, 1'b0, 1'b0, 1);   // R10 prev 31 -> flag
    // constrained random
    for (int f = 0; f < 40; f++) begin
      bit par = $urandom;
      int n = 4 + ($urandom % 40);
      runFrame(n, par, bit'($urandom), 1 + ($urandom % 3));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule